// File: doc/BRIEF.md
# Reference Monitor and Switchover Controller

This block supervises two reference clocks and a crystal clock, and picks the reference that drives a downstream loop. All three clocks and the loop feedback clock come in as raw asynchronous levels. The block samples them in a fast system clock and turns each rising edge into a one-cycle pulse. After each feedback edge, each reference must produce an edge inside a programmable lock window. The crystal must produce each edge within a fixed window after its own previous edge. A missed window marks that input bad. The flag clears by itself after a run of in-window edges.

A selector picks the active reference under one of three policies: forced by a select input, revertive toward a preferred input, or non-revertive. It reports the choice on `active_o`. When the active reference is bad, the block raises holdover and freezes its registered copy of the loop control word. A lock flag rises after a run of clean edges on the active reference. All status outputs come straight from registers or from simple gating of registers, so they can be mirrored on pins.

Top module: `refmon_switch`

## Requirements
- R1: Each input has its own bad flag (`ref0_bad_o`, `ref1_bad_o`, `xtal_bad_o`), where 1 means bad. All three flags are 1 out of reset. A flag is set when no rising edge of that input arrives while its window is open. For a reference, the window opens on each feedback edge. For the crystal, it opens on each crystal edge and lasts `XTAL_WIN_CYC` cycles.
- R2: A bad flag clears by itself after `GOOD_EDGES` (4) consecutive in-window edges. A missed window restarts that count.
- R3: `win_sel_i` sets the reference window length to `CYC_PER_US * 2^(code+1)` system cycles: code 00 gives 2 us, 01 gives 4 us, 10 gives 8 us and 11 gives 16 us.
- R4: With `mode_i` = 01 (revertive), the active input is `pref_i` whenever that input is good. Otherwise it is the other input if that one is good. Otherwise it stays unchanged.
- R5: With `mode_i` = 10 or 11 (non-revertive), the active input changes only when it is bad and the other input is good. A recovered input does not take the selection back.
- R6: With `mode_i` = 00 (manual), the active input equals `pref_i`, even when that input is bad. A failure of the forced input raises holdover and causes no switch.
- R7: `active_o` gives the selected reference (0 = ref0, 1 = ref1), resets to 0 and follows fail-over changes without any software action.
- R8: `holdover_o` equals the bad flag of the active input. `ctrl_o` copies `ctrl_i` one cycle later while holdover is low, and holds its last value while holdover is high. It resets to 0.
- R9: `lock_o` goes to 1 once the active input has made `LOCK_EDGES` in-window edges while good, with no miss and no switch since. Any miss on the active input or any change of selection returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system sampling clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| ref0_i | input | 1 | raw reference clock 0 |
| ref1_i | input | 1 | raw reference clock 1 |
| xtal_i | input | 1 | raw crystal clock |
| fb_i | input | 1 | raw loop feedback clock |
| mode_i | input | 2 | switchover policy: 00 manual, 01 revertive, 1x non-revertive |
| pref_i | input | 1 | forced input (manual) or preferred input (revertive) |
| win_sel_i | input | 2 | lock window code |
| ctrl_i | input | CW | loop control word from the loop filter |
| ref0_bad_o | output | 1 | reference 0 bad flag |
| ref1_bad_o | output | 1 | reference 1 bad flag |
| xtal_bad_o | output | 1 | crystal bad flag |
| active_o | output | 1 | selected reference |
| holdover_o | output | 1 | selected reference unusable |
| lock_o | output | 1 | lock indicator |
| ctrl_o | output | CW | control word, frozen during holdover |

## Verification
The bench builds the block with `CYC_PER_US` = 4, `XTAL_WIN_CYC` = 16, `LOCK_EDGES` = 4 and `CW` = 8. This makes the four window codes 8, 16, 32 and 64 cycles, so a reference edge placed 14 cycles after feedback misses under code 00 and lands under codes 01 and 11, all within a 20-cycle feedback period. The short lock count makes both the rise of the lock flag and its clearing on a switch reachable within a few periods. The small crystal window lets the bench starve the crystal and watch it recover within a few dozen cycles.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
  typedef enum logic [1:0] {
    SW_MANUAL  = 2'b00,
    SW_REVERT  = 2'b01,
    SW_NONREV  = 2'b10,
    SW_NONREV2 = 2'b11
  } sw_mode_e;

  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned SRC_XTAL = 2;
endpackage

// File: rtl/refmon_edge.sv
module refmon_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/refmon_window.sv
module refmon_window #(
  parameter int unsigned WIN_W      = 8,
  parameter int unsigned GOOD_EDGES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             mark_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             bad_o,
  output logic             hit_o,
  output logic             miss_o
);
  localparam int unsigned GC_W = $clog2(GOOD_EDGES + 1);

  logic             open_q;
  logic [WIN_W-1:0] cnt_q;
  logic             bad_q;
  logic [GC_W-1:0]  good_q;

  assign hit_o  = open_q & edge_i;
  assign miss_o = open_q & ~edge_i & (cnt_q == '0);

  // window timer: opens on mark, closes on hit or expiry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (mark_i) begin
      open_q <= 1'b1;
      cnt_q  <= win_len_i - WIN_W'(1);
    end else if (hit_o || miss_o) begin
      open_q <= 1'b0;
    end else if (open_q) begin
      cnt_q <= cnt_q - WIN_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bad_q  <= 1'b1;
      good_q <= '0;
    end else if (miss_o) begin
      bad_q  <= 1'b1;
      good_q <= '0;
    end else if (hit_o && bad_q) begin
      if (good_q == GC_W'(GOOD_EDGES - 1)) begin
        bad_q  <= 1'b0;
        good_q <= '0;
      end else begin
        good_q <= good_q + GC_W'(1);
      end
    end
  end

  assign bad_o = bad_q;

  // R1: a bad flag only rises while a window was open
  p_bad_rise_in_window_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bad_q) |-> $past(open_q));
  // R2: a bad flag only clears on an edge
  p_clear_on_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bad_q) |-> $past(edge_i));
endmodule

// File: rtl/refmon_select.sv
module refmon_select
  import refmon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       pref_i,
  input  logic [1:0] bad_i,
  output logic       sel_o,
  output logic       chg_o
);
  sw_mode_e mode;
  logic     sel_q, sel_d;

  assign mode = sw_mode_e'(mode_i);

  always_comb begin
    sel_d = sel_q;
    unique case (mode)
      SW_MANUAL: sel_d = pref_i;
      SW_REVERT: begin
        if (!bad_i[pref_i])       sel_d = pref_i;
        else if (!bad_i[!pref_i]) sel_d = !pref_i;
      end
      default: begin
        if (bad_i[sel_q] && !bad_i[!sel_q]) sel_d = !sel_q;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel_d;
  end

  assign sel_o = sel_q;
  assign chg_o = sel_d != sel_q;

  p_revert_pref_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == SW_REVERT && !bad_i[pref_i]) |=> (sel_q == $past(pref_i)));
  p_nonrev_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode == SW_NONREV || mode == SW_NONREV2) && !bad_i[sel_q]) |=> $stable(sel_q));
  p_manual_force_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == SW_MANUAL) |=> (sel_q == $past(pref_i)));
endmodule

// File: rtl/refmon_switch.sv
module refmon_switch
  import refmon_pkg::*;
#(
  parameter int unsigned CYC_PER_US   = 200,
  parameter int unsigned XTAL_WIN_CYC = 64,
  parameter int unsigned GOOD_EDGES   = 4,
  parameter int unsigned LOCK_EDGES   = 16,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned CW           = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref0_i,
  input  logic          ref1_i,
  input  logic          xtal_i,
  input  logic          fb_i,
  input  logic [1:0]    mode_i,
  input  logic          pref_i,
  input  logic [1:0]    win_sel_i,
  input  logic [CW-1:0] ctrl_i,
  output logic          ref0_bad_o,
  output logic          ref1_bad_o,
  output logic          xtal_bad_o,
  output logic          active_o,
  output logic          holdover_o,
  output logic          lock_o,
  output logic [CW-1:0] ctrl_o
);
  localparam int unsigned REF_MAX = CYC_PER_US * 16;
  localparam int unsigned WIN_MAX = (REF_MAX > XTAL_WIN_CYC) ? REF_MAX : XTAL_WIN_CYC;
  localparam int unsigned WIN_W   = $clog2(WIN_MAX + 1);
  localparam int unsigned LC_W    = $clog2(LOCK_EDGES + 1);

  logic [NUM_SRC-1:0] raw, rise, mark, bad, hit, miss;
  logic [WIN_W-1:0]   win_len [NUM_SRC];
  logic               fb_rise;
  logic [WIN_W-1:0]   ref_win;
  logic               sel, chg;
  logic [LC_W-1:0]    lock_q;
  logic [CW-1:0]      ctrl_q;

  assign raw     = {xtal_i, ref1_i, ref0_i};
  assign ref_win = WIN_W'(CYC_PER_US) << ({1'b0, win_sel_i} + 3'd1);

  refmon_edge #(.SYNC_STAGES(SYNC_STAGES)) u_fb_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(fb_i), .rise_o(fb_rise)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    refmon_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw[g]), .rise_o(rise[g])
    );
    if (g == SRC_XTAL) begin : g_self
      assign mark[g]    = rise[g];
      assign win_len[g] = WIN_W'(XTAL_WIN_CYC);
    end else begin : g_fb
      assign mark[g]    = fb_rise;
      assign win_len[g] = ref_win;
    end
    refmon_window #(.WIN_W(WIN_W), .GOOD_EDGES(GOOD_EDGES)) u_win (
      .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(rise[g]), .mark_i(mark[g]),
      .win_len_i(win_len[g]), .bad_o(bad[g]), .hit_o(hit[g]), .miss_o(miss[g])
    );
  end

  refmon_select u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .pref_i(pref_i),
    .bad_i(bad[1:0]), .sel_o(sel), .chg_o(chg)
  );

  // lock run counter on the active reference
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                lock_q <= '0;
    else if (miss[sel] || chg)                  lock_q <= '0;
    else if (hit[sel] && !bad[sel] && lock_q != LC_W'(LOCK_EDGES))
                                                lock_q <= lock_q + LC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ctrl_q <= '0;
    else if (!bad[sel])  ctrl_q <= ctrl_i;
  end

  assign ref0_bad_o = bad[0];
  assign ref1_bad_o = bad[1];
  assign xtal_bad_o = bad[SRC_XTAL];
  assign active_o   = sel;
  assign holdover_o = bad[sel];
  assign lock_o     = lock_q == LC_W'(LOCK_EDGES);
  assign ctrl_o     = ctrl_q;

  p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    holdover_o |=> $stable(ctrl_o));
  p_lock_not_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> !holdover_o);
  p_lock_drop_switch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(active_o) |-> !lock_o);
endmodule

// File: tb/refmon_switch_tb.sv
module refmon_switch_tb;
  localparam int CW  = 8;
  localparam int PER = 20;

  typedef struct packed {
    int         req;
    logic [5:0] st;
    logic [5:0] msk;
    logic [7:0] ctrl;
    logic       cc;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic r0 = 0, r1 = 0, xt = 0, fb = 0;
  logic [1:0] mode = 2'b01, win = 2'b00;
  logic pref = 1'b0;
  logic [CW-1:0] ctrl_in = '0;
  logic b0, b1, bx, act, hold, lock;
  logic [CW-1:0] ctrl_out;

  int checks = 0, failures = 0;
  bit en0 = 1, en1 = 1, enx = 1;
  int d0 = 3, d1 = 3;
  item_t sb[$];

  always #2.5 clk = ~clk;

  refmon_switch #(.CYC_PER_US(4), .XTAL_WIN_CYC(16), .GOOD_EDGES(4),
                  .LOCK_EDGES(4), .SYNC_STAGES(2), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref0_i(r0), .ref1_i(r1), .xtal_i(xt), .fb_i(fb),
    .mode_i(mode), .pref_i(pref), .win_sel_i(win), .ctrl_i(ctrl_in),
    .ref0_bad_o(b0), .ref1_bad_o(b1), .xtal_bad_o(bx), .active_o(act),
    .holdover_o(hold), .lock_o(lock), .ctrl_o(ctrl_out)
  );

  task automatic run(input int n);
    for (int p = 0; p < n; p++)
      for (int c = 0; c < PER; c++) begin
        @(negedge clk);
        fb = (c < 2);
        r0 = en0 && c >= d0 && c < d0 + 2;
        r1 = en1 && c >= d1 && c < d1 + 2;
        xt = enx && (c % 10) < 2;
      end
  endtask

  // st = {xtal_bad, ref1_bad, ref0_bad, active, holdover, lock}
  task automatic expect_st(input int req, input logic [5:0] st, input logic [5:0] msk,
                           input logic [7:0] cv, input logic cc);
    item_t it;
    it.req = req; it.st = st; it.msk = msk; it.ctrl = cv; it.cc = cc;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  initial begin : monitor
    forever begin
      item_t it;
      logic [5:0] got;
      wait (sb.size() != 0);
      @(negedge clk);
      it  = sb.pop_front();
      got = {bx, b1, b0, act, hold, lock};
      checks++;
      if (((got ^ it.st) & it.msk) != 0) begin
        failures++;
        $display("FAIL R%0d status actual=%b expected=%b mask=%b", it.req, got, it.st, it.msk);
      end
      if (it.cc) begin
        checks++;
        if (ctrl_out !== it.ctrl) begin
          failures++;
          $display("FAIL R%0d ctrl actual=%h expected=%h", it.req, ctrl_out, it.ctrl);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: all requirements, actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_st(1, 6'b111_010, 6'b111_111, 8'h00, 1'b1);   // R1 R7 R8 reset state
    ctrl_in = 8'h5A;
    run(10);
    expect_st(2, 6'b000_001, 6'b111_111, 8'h5A, 1'b1);   // R2 R9 recovery and lock
    en0 = 0; run(2);
    expect_st(7, 6'b001_100, 6'b111_111, 8'h00, 1'b0);   // R7 R4 R9 fail-over to ref1
    en0 = 1; run(3);
    expect_st(2, 6'b001_100, 6'b011_110, 8'h00, 1'b0);   // R2 three edges not enough
    run(1);
    expect_st(4, 6'b000_000, 6'b011_110, 8'h00, 1'b0);   // R4 revert to preferred
    mode = 2'b10; en0 = 0; run(2);
    expect_st(5, 6'b001_100, 6'b011_110, 8'h00, 1'b0);   // R5 fail-over
    en0 = 1; run(6);
    expect_st(5, 6'b000_100, 6'b011_110, 8'h00, 1'b0);   // R5 no return
    mode = 2'b00; pref = 1'b1; run(2);
    ctrl_in = 8'hC3; run(1);
    expect_st(8, 6'b000_100, 6'b011_110, 8'hC3, 1'b1);   // R8 tracking
    en1 = 0; run(2);
    expect_st(6, 6'b010_110, 6'b011_111, 8'hC3, 1'b1);   // R6 no switch, holdover
    ctrl_in = 8'h11; run(1);
    expect_st(8, 6'b010_110, 6'b011_110, 8'hC3, 1'b1);   // R8 frozen
    en1 = 1; run(5);
    expect_st(8, 6'b000_100, 6'b011_110, 8'h11, 1'b1);   // R8 thaw
    pref = 1'b0; run(1);
    expect_st(6, 6'b000_000, 6'b011_110, 8'h00, 1'b0);   // R6 forced to ref0
    d0 = 14; run(2);
    expect_st(3, 6'b001_010, 6'b011_110, 8'h00, 1'b0);   // R3 code 00 too short
    win = 2'b01; run(5);
    expect_st(3, 6'b000_000, 6'b011_110, 8'h00, 1'b0);   // R3 code 01 long enough
    win = 2'b11; run(4);
    expect_st(3, 6'b000_000, 6'b011_110, 8'h00, 1'b0);   // R3 code 11
    win = 2'b00; run(1);
    expect_st(3, 6'b001_010, 6'b011_110, 8'h00, 1'b0);   // R3 back to 00
    d0 = 3; run(5);
    expect_st(2, 6'b000_000, 6'b011_110, 8'h00, 1'b0);   // R2 ref0 good again
    enx = 0; run(2);
    expect_st(1, 6'b100_000, 6'b111_110, 8'h00, 1'b0);   // R1 crystal starved
    enx = 1; run(1);
    expect_st(2, 6'b100_000, 6'b100_000, 8'h00, 1'b0);   // R2 crystal not yet clear
    run(2);
    expect_st(2, 6'b000_000, 6'b111_110, 8'h00, 1'b0);   // R2 crystal clears
    run(1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule